// File: doc/BRIEF.md
# Serial ADC Burst Sequencer

This block is the master side of a serial-control successive-approximation converter link. For each conversion it asserts chip select low. It runs sixteen serial clocks and shifts out a 16-bit control word most significant bit first. At the same time it shifts in the result that the converter holds from the previous burst. It then keeps chip select high for a minimum idle interval before it accepts another start.

The word has two bytes. The first byte is the converter command: channel, data length, result bit order and polarity mode. The converter does not use the second byte. That byte carries control for an isolated analog front end: lead choice, analog mux address and an odd-parity bit. When the isolated side sees bad parity, it forces the sample to full scale. For this reason a returned all-ones code is reported as an error.

The read-back is pipelined. The result reported at the end of a burst belongs to the command of the burst before it, and its bit order follows that earlier command. The serial clock and the idle interval are set in system clock cycles by parameters. The defaults give a 25 kHz serial clock and an 80 microsecond gap from a 50 MHz system clock.

Top module: `adc_burst_seq`

## Requirements
- R1: Word bits 15:12 carry the channel, 11:10 the data length, bit 9 the result order (0 MSB first, 1 LSB first) and bit 8 the polarity mode. The word is sent most significant bit first.
- R2: Word bits 7:6 carry the lead choice (00 test, 01 lead I, 10 lead II, 11 lead III). Bits 5:3 carry the mux address (000 ECG, 001 QRS, 010 pacing, 011 respiration, 100 lead-off, 101 calibration, 111 gain). Bit 2 makes bits 7:2 odd parity, and bits 1:0 are zero.
- R3: Each burst has exactly sixteen serial clock pulses with chip select low for the whole burst. The serial clock idles low and pulses only while chip select is low.
- R4: The data-in line changes only on a falling serial clock edge. The data-out line is sampled on each rising edge.
- R5: The 12-bit result reported at the end of a burst is made of the first twelve bits received in that burst, so it is the conversion commanded by the previous burst. After reset the first burst reports whatever the converter returns, with MSB-first order assumed.
- R6: When the previous burst's order bit is 1, the received bits are taken as LSB first and reassembled into the normal result.
- R7: The error output is high with the valid pulse exactly when the reported result is all ones. At any other time it is low.
- R8: Between the end of one burst and the start of the next, chip select stays high for at least GAP_CYCLES system cycles. A start while busy is ignored.
- R9: A start that requests mux address 110 is refused. No burst begins and busy stays low.
- R10: During and after reset, chip select is high, the serial clock is low, and busy and valid are low.
- R11: The valid output pulses for one cycle, in the same cycle chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| chan_i | input | 4 | Converter channel address |
| len_i | input | 2 | Converter data length code |
| lsb_first_i | input | 1 | Result order request for this conversion |
| bipolar_i | input | 1 | Polarity mode request |
| lead_i | input | 2 | Isolated-side lead choice |
| mux_i | input | 3 | Isolated-side mux address |
| ser_in_i | input | 1 | Serial data returned by the converter |
| busy_o | output | 1 | High from accepted start until the gap ends |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to the converter |
| rdy_o | output | 1 | One-cycle result valid pulse |
| result_o | output | 12 | Reassembled result |
| err_o | output | 1 | All-ones error flag, with rdy_o |

## Verification
A start sampled at a clock edge gives busy high and chip select low after that edge. The first serial clock rise comes HALF_DIV cycles later, and each half period after that lasts HALF_DIV cycles. The result, the error flag and the valid pulse appear in the same cycle that chip select rises, which is the cycle after the sixteenth falling tick. The bench samples every output at the falling system clock edge. In one process it compares rdy_o, result_o and err_o in the cycle where it also sees chip select rise, and only after that does it load the converter model's next return value. The gap is counted in whole cycles from that chip select rise to the next fall.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int WORD_W = 16;
    localparam int RES_W  = 12;

    typedef enum logic [1:0] {
        LEAD_TEST = 2'b00,
        LEAD_I    = 2'b01,
        LEAD_II   = 2'b10,
        LEAD_III  = 2'b11
    } lead_e;

    typedef enum logic [2:0] {
        MUX_ECG     = 3'b000,
        MUX_QRS     = 3'b001,
        MUX_PACE    = 3'b010,
        MUX_RESP    = 3'b011,
        MUX_LEADOFF = 3'b100,
        MUX_CAL     = 3'b101,
        MUX_RSVD    = 3'b110,
        MUX_GAIN    = 3'b111
    } mux_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } state_e;

    typedef struct packed {
        logic [3:0] chan;
        logic [1:0] len;
        logic       lsb_first;
        logic       bipolar;
    } conv_cmd_t;

    typedef struct packed {
        lead_e      lead;
        mux_e       mux;
        logic       parity;
        logic [1:0] spare;
    } iso_ctl_t;

    typedef struct packed {
        conv_cmd_t cmd;
        iso_ctl_t  iso;
    } burst_word_t;

    function automatic logic odd_fill(lead_e l, mux_e m);
        return ~^{l, m};
    endfunction

    function automatic logic mux_legal(logic [2:0] m);
        return m != MUX_RSVD;
    endfunction

    function automatic burst_word_t pack_word(logic [3:0] ch, logic [1:0] ln,
                                              logic lsb, logic bip,
                                              lead_e l, mux_e m);
        burst_word_t w;
        w.cmd.chan      = ch;
        w.cmd.len       = ln;
        w.cmd.lsb_first = lsb;
        w.cmd.bipolar   = bip;
        w.iso.lead      = l;
        w.iso.mux       = m;
        w.iso.parity    = odd_fill(l, m);
        w.iso.spare     = 2'b00;
        return w;
    endfunction

    function automatic logic [RES_W-1:0] flip_res(logic [RES_W-1:0] x);
        logic [RES_W-1:0] y;
        for (int i = 0; i < RES_W; i++) y[i] = x[RES_W-1-i];
        return y;
    endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
    parameter int HALF_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)                       cnt_q <= '0;
        else if (cnt_q == CW'(HALF_DIV - 1))   cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter
    import adcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              active,
    input  logic              tick,
    input  logic              ser_in,
    output logic              sclk,
    output logic              dout,
    output logic [RES_W-1:0]  rx_head,
    output logic              last_fall
);
    localparam int EW = $clog2(WORD_W + 1);

    logic              sclk_q;
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [EW-1:0]     fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
            fall_q <= '0;
        end else if (load) begin
            sclk_q <= 1'b0;
            tx_q   <= load_word;
            fall_q <= '0;
        end else if (active && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[WORD_W-2:0], ser_in};
            end else begin
                sclk_q <= 1'b0;
                fall_q <= fall_q + 1'b1;
                tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign sclk      = sclk_q;
    assign dout      = tx_q[WORD_W-1];
    assign rx_head   = rx_q[WORD_W-1 -: RES_W];
    assign last_fall = active && tick && sclk_q && (fall_q == EW'(WORD_W - 1));
endmodule

// File: rtl/adcseq_gap.sv
module adcseq_gap #(
    parameter int GAP_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == GW'(GAP_CYCLES - 1));
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adcseq_pkg::*;
#(
    parameter int HALF_DIV   = 1000,
    parameter int GAP_CYCLES = 4000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [3:0]       chan_i,
    input  logic [1:0]       len_i,
    input  logic             lsb_first_i,
    input  logic             bipolar_i,
    input  logic [1:0]       lead_i,
    input  logic [2:0]       mux_i,
    input  logic             ser_in_i,
    output logic             busy_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    output logic             rdy_o,
    output logic [RES_W-1:0] result_o,
    output logic             err_o
);
    state_e            state_q;
    logic              cs_n_q, rdy_q, err_q;
    logic [RES_W-1:0]  res_q;
    logic              ord_cur_q, ord_prev_q;

    logic              accept, in_shift, in_gap;
    logic              tick, last_fall, gap_done;
    logic [RES_W-1:0]  rx_head, res_asm;
    burst_word_t       word;

    assign in_shift = (state_q == ST_SHIFT);
    assign in_gap   = (state_q == ST_GAP);
    assign accept   = start_i && (state_q == ST_IDLE) && mux_legal(mux_i);
    assign word     = pack_word(chan_i, len_i, lsb_first_i, bipolar_i,
                                lead_e'(lead_i), mux_e'(mux_i));
    assign res_asm  = ord_prev_q ? flip_res(rx_head) : rx_head;

    adcseq_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (in_shift),
        .tick(tick)
    );

    adcseq_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_word(word),
        .active   (in_shift),
        .tick     (tick),
        .ser_in   (ser_in_i),
        .sclk     (sclk_o),
        .dout     (din_o),
        .rx_head  (rx_head),
        .last_fall(last_fall)
    );

    adcseq_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk (clk),
        .rst (rst),
        .run (in_gap),
        .done(gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cs_n_q     <= 1'b1;
            rdy_q      <= 1'b0;
            err_q      <= 1'b0;
            res_q      <= '0;
            ord_cur_q  <= 1'b0;
            ord_prev_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q    <= ST_SHIFT;
                    cs_n_q     <= 1'b0;
                    ord_prev_q <= ord_cur_q;
                    ord_cur_q  <= lsb_first_i;
                end
                ST_SHIFT: if (last_fall) begin
                    state_q <= ST_GAP;
                    cs_n_q  <= 1'b1;
                    rdy_q   <= 1'b1;
                    res_q   <= res_asm;
                    err_q   <= &res_asm;
                end
                ST_GAP: if (gap_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign cs_n_o   = cs_n_q;
    assign rdy_o    = rdy_q;
    assign result_o = res_q;
    assign err_o    = err_q;
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk #(
    parameter int GAP_CYCLES = 4000
) (
    input logic clk,
    input logic rst,
    input logic cs_n_o,
    input logic sclk_o,
    input logic din_o,
    input logic busy_o,
    input logic rdy_o,
    input logic err_o
);
    logic [31:0] hi_q;
    logic [4:0]  rise_q;
    logic        seen_q;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            rise_q <= '0;
            seen_q <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            seen_q <= seen_q | !cs_n_o;
            hi_q   <= cs_n_o ? hi_q + 1'b1 : '0;
            if (cs_n_o)                rise_q <= '0;
            else if (sclk_o && !sclk_d) rise_q <= rise_q + 1'b1;
        end
    end

    a_r3_clock_inside_burst: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);

    a_r3_sixteen_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> rise_q == 5'd16);

    a_r4_data_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $past(!cs_n_o) && !$fell(sclk_o)) |-> $stable(din_o));

    a_r8_min_gap: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n_o) && seen_q) |-> hi_q >= GAP_CYCLES);

    a_r8_busy_in_burst: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);

    a_r11_valid_at_end: assert property (@(posedge clk) disable iff (rst)
        rdy_o |-> $rose(cs_n_o));

    a_r7_err_only_with_valid: assert property (@(posedge clk) disable iff (rst)
        err_o |-> rdy_o);
endmodule

bind adc_burst_seq adc_burst_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n_o(cs_n_o),
    .sclk_o(sclk_o),
    .din_o (din_o),
    .busy_o(busy_o),
    .rdy_o (rdy_o),
    .err_o (err_o)
);

// File: tb/sim_adc_burst_seq.sv
module sim_adc_burst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int GAP        = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic [1:0]  len_i = '0;
    logic        lsb_first_i = 1'b0;
    logic        bipolar_i = 1'b0;
    logic [1:0]  lead_i = '0;
    logic [2:0]  mux_i = '0;
    logic        ser_in_i = 1'b0;
    logic        busy_o, cs_n_o, sclk_o, din_o, rdy_o, err_o;
    logic [11:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] exp_word = '0;
    logic [11:0] pend_val = '0;
    logic        pend_lsb = 1'b0;
    logic [15:0] cap = '0;
    int          idx = 0, rises = 0, hi_cnt = 0, bursts = 0;
    logic        cs_prev = 1'b1, sclk_prev = 1'b0, din_prev = 1'b0, din_bad = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_burst_seq #(.HALF_DIV(HALF), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .len_i(len_i),
        .lsb_first_i(lsb_first_i), .bipolar_i(bipolar_i), .lead_i(lead_i),
        .mux_i(mux_i), .ser_in_i(ser_in_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .din_o(din_o), .rdy_o(rdy_o), .result_o(result_o),
        .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter and isolated-side model plus per-cycle checks
    always @(negedge clk) begin
        if (!rst) begin
            if (rdy_o) begin
                if (pend_lsb) chk(result_o == pend_val, "R6 lsb-first result", result_o, pend_val);
                else          chk(result_o == pend_val, "R5 pipelined result", result_o, pend_val);
                chk(err_o == (pend_val == 12'hFFF), "R7 error flag", err_o, pend_val == 12'hFFF);
                chk(cs_n_o == 1'b1, "R11 valid with cs rise", cs_n_o, 1);
            end
            if (cs_prev && !cs_n_o) begin
                if (bursts > 0) chk(hi_cnt >= GAP, "R8 idle gap", hi_cnt, GAP);
                rises = 0; idx = 0; cap = '0; din_bad = 1'b0;
            end else if (!cs_n_o) begin
                if (!sclk_prev && sclk_o) begin
                    rises++;
                    cap = {cap[14:0], din_o};
                end
                if (sclk_prev && !sclk_o) idx++;
                else if (din_o != din_prev) din_bad = 1'b1;
            end
            if (!cs_prev && cs_n_o) begin
                chk(rises == 16, "R3 sixteen clocks", rises, 16);
                chk(cap[15:8] == exp_word[15:8], "R1 command byte", cap[15:8], exp_word[15:8]);
                chk(cap[7:0] == exp_word[7:0], "R2 isolated byte", cap[7:0], exp_word[7:0]);
                chk(!din_bad, "R4 data on falling edge", din_bad, 0);
                pend_lsb = exp_word[9];
                pend_val = (exp_word[15:12] == 4'hF) ? 12'hFFF
                         : 12'((exp_word[15:12] * 300 + bursts * 41) % 4095);
                bursts++;
                hi_cnt = 0;
            end
            if (cs_n_o) hi_cnt++;
            if (sclk_o && cs_n_o) chk(1'b0, "R3 clock outside burst", 1, 0);
            if (!cs_n_o && idx < 12) ser_in_i = pend_lsb ? pend_val[idx] : pend_val[11-idx];
            else                     ser_in_i = 1'b0;
            cs_prev = cs_n_o; sclk_prev = sclk_o; din_prev = din_o;
        end
    end

    task automatic launch(input logic [3:0] ch, input logic [1:0] ln, input logic ord,
                          input logic pol, input logic [1:0] ld, input logic [2:0] mx);
        while (busy_o) @(negedge clk);
        chan_i = ch; len_i = ln; lsb_first_i = ord; bipolar_i = pol;
        lead_i = ld; mux_i = mx;
        exp_word = {ch, ln, ord, pol, ld, mx, ~^{ld, mx}, 2'b00};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1 && sclk_o == 0 && busy_o == 0 && rdy_o == 0,
            "R10 reset state", {cs_n_o, sclk_o, busy_o, rdy_o}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n_o == 1 && busy_o == 0, "R10 after reset", {cs_n_o, busy_o}, 2'b10);

        for (int i = 0; i < 40; i++) begin
            int m;
            m = i % 7;
            if (m == 6) m = 7;
            launch(4'(i % 16), 2'(i % 4), 1'((i / 3) % 2), 1'(i % 2), 2'(i % 4), 3'(m));
        end
        while (busy_o) @(negedge clk);

        // R9: reserved mux code refused
        mux_i = 3'b110; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy_o == 0 && cs_n_o == 1, "R9 reserved mux refused", {busy_o, cs_n_o}, 2'b01);

        // R8: start during gap ignored
        launch(4'h3, 2'b01, 1'b0, 1'b0, 2'b10, 3'b011);
        while (cs_n_o == 0 || busy_o == 0) @(negedge clk);
        chk(busy_o == 1, "R8 busy during gap", busy_o, 1);
        mux_i = 3'b001; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(cs_n_o == 1 && busy_o == 0, "R8 start while busy ignored", {cs_n_o, busy_o}, 2'b10);

        // final burst flushes the last pending result
        launch(4'h1, 2'b00, 1'b0, 1'b1, 2'b01, 3'b000);
        while (busy_o) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule